// File: doc/BRIEF.md
# Averaging Setpoint and Duty Scaler

This block turns a stream of 10-bit converter readings into the two setting values of a PWM counter: an 8-bit period limit (the top) and an 8-bit compare value. The readings come from two channels that share one input, and each reading carries a one-bit channel tag. The block averages a group of eight frequency readings and then a group of eight width readings. It repeats this cycle without end.

The top comes from the frequency average. The compare value is the width average multiplied by the top, so the width setting behaves as a duty ratio. When the frequency setting moves, the pulse keeps the same share of the period, not the same number of counts. Both results go out together with a one-cycle strobe. The PWM counter can then load the pair without tearing.

Top module: `setpoint_scaler`

## Requirements
- R1: While reset is asserted, and after it is released until the first update, top_val and cmp_val are 0 and upd is 0.
- R2: A sample is accepted when smp_valid is 1 and smp_chan matches the active phase (0 = frequency, 1 = width). The block sums exactly eight accepted frequency samples, then exactly eight accepted width samples, and repeats this order continuously, starting with the frequency phase after reset.
- R3: The raw top is the eight-sample frequency sum shifted right by 5, with truncation.
- R4: When the raw top is below 2, top_val becomes 2. Otherwise top_val equals the raw top.
- R5: The raw compare is ((width sum >> 6) * raw top) >> 7, with truncation at each step. It uses the raw top from before the floor of R4 and has no overflow.
- R6: When the raw compare is 0, cmp_val becomes 1. Otherwise cmp_val equals the raw compare. Every updated cmp_val is below top_val.
- R7: top_val and cmp_val change only at the clock edge that accepts the eighth width sample, and they change together. upd is 1 for exactly the one cycle after that edge. Between updates both values hold.
- R8: A valid sample whose tag does not match the active phase is ignored. It adds nothing to the sum and does not count toward the eight.
- R9: Cycles with smp_valid at 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_chan | input | 1 | Sample tag: 0 = frequency, 1 = width |
| smp_data | input | 10 | Converter reading |
| top_val | output | 8 | Period limit for the PWM counter |
| cmp_val | output | 8 | Compare value for the PWM counter |
| upd | output | 1 | One-cycle strobe: a new top/compare pair is present |

## Verification
The embedded assertions check several properties on every cycle. The strobe never lasts two cycles. The top and compare values stay frozen whenever the strobe is low. Every update respects the floors and keeps the compare below the top. A mismatched tag never moves the phase. The partial sum also never exceeds the count of accepted samples times full scale. Only the bench's scenarios can show the arithmetic itself: the truncating shifts, the use of the unclamped top in the product, and the exact floor boundaries. The same holds for the claim that interleaved wrong-tag readings and idle gaps leave the sums untouched, which the bench sees in the values that come out.

// File: rtl/setpoint_pkg.sv
package setpoint_pkg;
  localparam int SMP_W   = 10;
  localparam int NUM_SMP = 8;
  localparam int OUT_W   = 8;
  localparam int PROD_W  = 17;

  typedef enum logic {PH_FREQ = 1'b0, PH_WIDTH = 1'b1} phase_t;
endpackage

// File: rtl/sample_accum.sv
module sample_accum #(
  parameter int DW  = 10,
  parameter int NUM = 8,
  localparam int CNT_W = $clog2(NUM),
  localparam int ACC_W = DW + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DW-1:0]    din,
  output logic [ACC_W-1:0] sum_nxt,
  output logic             last
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign sum_nxt = acc_q + ACC_W'(din);
  assign last    = (cnt_q == CNT_W'(NUM - 1));

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (en) begin
      acc_d = last ? '0 : sum_nxt;
      cnt_d = last ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R2
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(acc_q) <= int'(cnt_q) * ((1 << DW) - 1));
endmodule

// File: rtl/duty_calc.sv
module duty_calc #(
  parameter int ACC_W  = 13,
  parameter int OUT_W  = 8,
  parameter int PROD_W = 17,
  localparam int TOP_SH = ACC_W - OUT_W,
  localparam int WID_SH = ACC_W - (OUT_W - 1),
  localparam int CMP_SH = OUT_W - 1
) (
  input  logic [ACC_W-1:0] fsum,
  input  logic [ACC_W-1:0] wsum,
  output logic [OUT_W-1:0] top,
  output logic [OUT_W-1:0] cmp
);
  logic [OUT_W-1:0]  top_raw;
  logic [OUT_W-2:0]  wid_avg;
  logic [PROD_W-1:0] prod;
  logic [OUT_W-1:0]  cmp_raw;

  always_comb begin
    top_raw = OUT_W'(fsum >> TOP_SH);
    wid_avg = (OUT_W-1)'(wsum >> WID_SH);
    prod    = PROD_W'(wid_avg) * PROD_W'(top_raw);
    cmp_raw = OUT_W'(prod >> CMP_SH);
    top     = (top_raw < OUT_W'(2)) ? OUT_W'(2) : top_raw;
    cmp     = (cmp_raw == '0) ? OUT_W'(1) : cmp_raw;
  end
endmodule

// File: rtl/setpoint_scaler.sv
module setpoint_scaler
  import setpoint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             smp_chan,
  input  logic [SMP_W-1:0] smp_data,
  output logic [OUT_W-1:0] top_val,
  output logic [OUT_W-1:0] cmp_val,
  output logic             upd
);
  localparam int ACC_W = SMP_W + $clog2(NUM_SMP);

  phase_t           phase_q, phase_d;
  logic [ACC_W-1:0] fhold_q, fhold_d;
  logic [OUT_W-1:0] top_q, top_d, cmp_q, cmp_d;
  logic             upd_q, upd_d;
  logic             acc_en, grp_end, f_done, w_done;
  logic [ACC_W-1:0] sum_nxt;
  logic [OUT_W-1:0] top_c, cmp_c;

  assign acc_en  = smp_valid && (smp_chan == phase_q);
  assign f_done  = acc_en && grp_end && (phase_q == PH_FREQ);
  assign w_done  = acc_en && grp_end && (phase_q == PH_WIDTH);

  sample_accum #(.DW(SMP_W), .NUM(NUM_SMP)) u_accum (
    .clk(clk), .rst_n(rst_n), .en(acc_en), .din(smp_data),
    .sum_nxt(sum_nxt), .last(grp_end)
  );

  duty_calc #(.ACC_W(ACC_W), .OUT_W(OUT_W), .PROD_W(PROD_W)) u_calc (
    .fsum(fhold_q), .wsum(sum_nxt), .top(top_c), .cmp(cmp_c)
  );

  always_comb begin
    phase_d = phase_q;
    fhold_d = fhold_q;
    top_d   = top_q;
    cmp_d   = cmp_q;
    upd_d   = w_done;
    if (f_done) begin
      fhold_d = sum_nxt;
      phase_d = PH_WIDTH;
    end
    if (w_done) begin
      top_d   = top_c;
      cmp_d   = cmp_c;
      phase_d = PH_FREQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FREQ;
      fhold_q <= '0;
      top_q   <= '0;
      cmp_q   <= '0;
      upd_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      upd_q   <= upd_d;
      if (f_done) fhold_q <= fhold_d;
      if (w_done) begin
        top_q <= top_d;
        cmp_q <= cmp_d;
      end
    end
  end

  assign top_val = top_q;
  assign cmp_val = cmp_q;
  assign upd     = upd_q;

  // R7
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> ($stable(top_q) && $stable(cmp_q)));
  // R4
  top_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> top_q >= OUT_W'(2));
  // R6
  cmp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (cmp_q != '0) && (cmp_q < top_q));
  // R8
  wrong_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_chan != phase_q)) |=> $stable(phase_q));
endmodule

// File: tb/setpoint_scaler_bench.sv
module setpoint_scaler_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_valid;
  logic       smp_chan;
  logic [9:0] smp_data;
  logic [7:0] top_val, cmp_val;
  logic       upd;

  always #4 clk = ~clk;

  setpoint_scaler u_setpoint_scaler (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .top_val(top_val), .cmp_val(cmp_val), .upd(upd)
  );

  int total = 0;
  int bad = 0;
  int n_upd = 0;
  int n_exp = 0;
  logic [7:0] q_top[$];
  logic [7:0] q_cmp[$];
  string      q_req[$];
  logic [7:0] last_top = 8'd0;
  logic [7:0] last_cmp = 8'd0;
  bit         mon_on = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(bit tag, int d);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_chan  = tag;
    smp_data  = 10'(d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      smp_data  = 10'h3ff;
    end
  endtask

  // Push the expected pair, then drive eight frequency and eight width samples.
  task automatic run_set(int fb, int fs, int wb, int ws, bit noise, string req);
    int fsum = 0, wsum = 0, rt, t, p, c;
    for (int i = 0; i < 8; i++) begin
      fsum += (fb + i * fs) % 1024;
      wsum += (wb + i * ws) % 1024;
    end
    rt = fsum >> 5;
    t  = (rt < 2) ? 2 : rt;
    p  = ((wsum >> 6) * rt) >> 7;
    c  = (p == 0) ? 1 : p;
    q_top.push_back(8'(t));
    q_cmp.push_back(8'(c));
    q_req.push_back(req);
    n_exp++;
    for (int i = 0; i < 8; i++) begin
      if (noise) begin
        send(1'b1, 1023);   // R8 wrong tag in frequency phase
        idle(i % 3);        // R9 gaps
      end
      send(1'b0, (fb + i * fs) % 1024);
    end
    for (int i = 0; i < 8; i++) begin
      if (noise) begin
        send(1'b0, 1023);   // R8 wrong tag in width phase
        idle(1);
      end
      send(1'b1, (wb + i * ws) % 1024);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (upd) begin
        n_upd++;
        if (q_top.size() == 0) begin
          chk(1'b0, "R7", "unexpected upd", 1, 0);
        end else begin
          logic [7:0] et, ec;
          string r;
          et = q_top.pop_front();
          ec = q_cmp.pop_front();
          r  = q_req.pop_front();
          chk(top_val == et, r, "top_val", top_val, et);
          chk(cmp_val == ec, r, "cmp_val", cmp_val, ec);
        end
        last_top = top_val;
        last_cmp = cmp_val;
      end else begin
        chk(top_val == last_top && cmp_val == last_cmp, "R7", "hold top",
            top_val, last_top);
      end
    end
  end

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog expired (R7) actual=%0d expected=%0d", n_upd, n_exp);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_chan = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    chk(top_val == 8'd0, "R1", "reset top", top_val, 0);
    chk(cmp_val == 8'd0, "R1", "reset cmp", cmp_val, 0);
    chk(upd == 1'b0, "R1", "reset upd", upd, 0);
    // R8/R1: wrong-tag samples before the first group change nothing
    @(negedge clk); rst_n = 1'b1;
    mon_on = 1'b1;
    send(1'b1, 1023); send(1'b1, 500); idle(2);
    chk(top_val == 8'd0 && upd == 1'b0, "R1", "post-reset top", top_val, 0);

    run_set(1023, 0, 1023, 0, 1'b0, "R2 R3 R5 full scale");   // 255 / 253
    run_set(400, 0, 512, 0, 1'b0, "R3 R5 mid");               // 100 / 50
    run_set(10, 130, 100, 90, 1'b0, "R3 R5 ramp");
    idle(4);
    run_set(0, 0, 0, 0, 1'b0, "R4 R6 zero");                  // 2 / 1
    run_set(7, 0, 1023, 0, 1'b0, "R4 R6 raw top 1");          // 2 / 1
    run_set(8, 0, 1023, 0, 1'b0, "R4 boundary raw 2");        // 2 / 1
    run_set(1023, 0, 8, 0, 1'b0, "R5 small width");           // 255 / 1
    run_set(1023, 0, 7, 0, 1'b0, "R6 zero compare");          // 255 / 1
    run_set(600, 13, 300, 41, 1'b1, "R8 R9 interleaved");
    run_set(90, 111, 700, 37, 1'b1, "R8 R9 interleaved 2");
    run_set(800, 3, 640, 5, 1'b0, "R2 back to back");
    idle(6);
    chk(q_top.size() == 0, "R7", "pending updates", q_top.size(), 0);
    chk(n_upd == n_exp, "R2", "update count", n_upd, n_exp);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule